// File: doc/BRIEF.md
# Programmable raster LCD timing generator

This block generates the raster timing for an LCD panel. It produces horizontal sync, vertical sync, an output-enable (data enable) pin, an active-pixel strobe, a one-cycle frame-start pulse, a panel clock, and the column and row of the pixel currently being scanned. Software describes the geometry in three 32-bit words: a horizontal word, a vertical word and a clock/polarity word. The block decodes these words into segment lengths and runs a pixel counter and a line counter against those lengths.

One pixel lasts two clock cycles. The panel clock is low for the first cycle of each pixel and high for the second, unless it is inverted. Each line is scanned as sync, back porch, active pixels, then front porch. Each frame follows the same order counted in lines. In dual-panel mode the vertical word gives the height of one panel half. Both halves are scanned together, so the block also drives a lower-half strobe and the lower-half row number.

The timing words are copied into a shadow bank while the block is disabled and again at each frame boundary. A frame therefore never runs on mixed timing. While the enable input is low, the counters stay cleared and every output holds its inactive level.

Top module: `lcd_timing_gen`

## Requirements
- R1: Horizontal word layout: bits 7:2 hold (active pixels/16 − 1), bits 15:8 hold (hsync width − 1), bits 23:16 hold (front porch − 1) and bits 31:24 hold (back porch − 1). A line lasts the sum of these four lengths in pixels.
- R2: Vertical word layout: bits 9:0 hold (active lines − 1) and bits 15:10 hold (vsync width − 1). Bits 23:16 hold the front porch and bits 31:24 hold the back porch, both used as written, so zero is allowed. A frame lasts the sum of the four lengths in lines.
- R3: Every line runs in the order sync, back porch, active, front porch, and every frame runs in the same order counted in lines. The active-pixel strobe is high only when both counters are in their active segments.
- R4: Each pixel lasts two clock cycles. The panel clock equals bit 13 of the clock/polarity word during the first cycle of a pixel and its complement during the second.
- R5: The sync pins and the output-enable pin are active high. Bit 11 of the clock/polarity word inverts vsync, bit 12 inverts hsync and bit 14 inverts output enable.
- R6: Frame start is a pulse one clock cycle long, given in the first cycle of the first active pixel of active line 0. It occurs exactly once per frame.
- R7: New values in the timing words take effect only at the next frame boundary, which is the start of vertical sync. While the block is disabled they take effect at once.
- R8: While the enable input is low (seen one cycle later), the counters stay cleared. The strobe, frame start and positions read 0, and the syncs, output enable and panel clock hold their inactive levels.
- R9: With dual-panel mode on, the lower strobe follows the active strobe and the lower row equals the row plus the active line count. With dual-panel mode off, both read 0.
- R10: During active pixels, the column counts from 0 to (active pixels − 1) and the row counts from 0 to (active lines − 1). Outside the active region both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two cycles per pixel |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| dual_panel | input | 1 | Scan upper and lower halves together |
| htim | input | 32 | Horizontal timing word |
| vtim | input | 32 | Vertical timing word |
| ctim | input | 32 | Clock and polarity word |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Output enable, polarity applied |
| pix_act | output | 1 | Active-pixel strobe, always active high |
| lo_act | output | 1 | Lower-half active strobe in dual mode |
| frame_start | output | 1 | One-cycle pulse at the first active pixel of a frame |
| panel_clk | output | 1 | Panel clock, polarity applied |
| x_pos | output | 12 | Active column |
| y_pos | output | 11 | Active row (upper half in dual mode) |
| y_lo_pos | output | 11 | Lower-half row in dual mode |

## Verification
Some properties are checked on every cycle. The active strobe never overlaps either sync segment. Frame start never lasts two cycles. The lower strobe appears only in dual mode alongside the main strobe. Nothing moves while the block is disabled. The shadow bank changes only when a load is allowed. A position counter never moves between pixel ticks and never passes the end of its period.

Other properties show only in the bench scenarios. These are the exact period and segment lengths decoded from each field layout, the effect of each polarity bit at the pins, and the remaining time after a mid-frame register write. The scenarios also cover zero-length vertical porches, a single active line, the first-pixel panel-clock phase and the outputs right after disable.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    // counter widths
    localparam int H_W = 12;
    localparam int V_W = 11;

    // horizontal word fields
    localparam int HPPL_LSB  = 2;
    localparam int HPPL_W    = 6;
    localparam int HSW_LSB   = 8;
    localparam int HFP_LSB   = 16;
    localparam int HBP_LSB   = 24;
    localparam int HSEG_W    = 8;
    localparam int PPL_SHIFT = 4;

    // vertical word fields
    localparam int VLPP_LSB = 0;
    localparam int VLPP_W   = 10;
    localparam int VSW_LSB  = 10;
    localparam int VSW_W    = 6;
    localparam int VFP_LSB  = 16;
    localparam int VBP_LSB  = 24;
    localparam int VSEG_W   = 8;

    // clock/polarity word bits
    localparam int INV_VS_BIT = 11;
    localparam int INV_HS_BIT = 12;
    localparam int INV_PC_BIT = 13;
    localparam int INV_OE_BIT = 14;

    typedef struct packed {
        logic [H_W-1:0] hsw;
        logic [H_W-1:0] hbp;
        logic [H_W-1:0] hact;
        logic [H_W-1:0] hfp;
        logic [V_W-1:0] vsw;
        logic [V_W-1:0] vbp;
        logic [V_W-1:0] vact;
        logic [V_W-1:0] vfp;
        logic           dual;
        logic           inv_vs;
        logic           inv_hs;
        logic           inv_pc;
        logic           inv_oe;
    } tcfg_t;

    typedef struct packed {
        logic en;
        logic phase;
    } ctl_t;

    function automatic tcfg_t decode_cfg(input logic [31:0] h,
                                         input logic [31:0] v,
                                         input logic [31:0] c,
                                         input logic        dual);
        tcfg_t t;
        t.hsw    = H_W'(h[HSW_LSB +: HSEG_W]) + H_W'(1);
        t.hbp    = H_W'(h[HBP_LSB +: HSEG_W]) + H_W'(1);
        t.hfp    = H_W'(h[HFP_LSB +: HSEG_W]) + H_W'(1);
        t.hact   = (H_W'(h[HPPL_LSB +: HPPL_W]) + H_W'(1)) << PPL_SHIFT;
        t.vact   = V_W'(v[VLPP_LSB +: VLPP_W]) + V_W'(1);
        t.vsw    = V_W'(v[VSW_LSB +: VSW_W]) + V_W'(1);
        t.vfp    = V_W'(v[VFP_LSB +: VSEG_W]);
        t.vbp    = V_W'(v[VBP_LSB +: VSEG_W]);
        t.dual   = dual;
        t.inv_vs = c[INV_VS_BIT];
        t.inv_hs = c[INV_HS_BIT];
        t.inv_pc = c[INV_PC_BIT];
        t.inv_oe = c[INV_OE_BIT];
        return t;
    endfunction

endpackage

// File: rtl/lcd_tim_shadow.sv
module lcd_tim_shadow
    import lcd_tim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] htim_i,
    input  logic [31:0] vtim_i,
    input  logic [31:0] ctim_i,
    input  logic        dual_i,
    output tcfg_t       cfg_o
);

    tcfg_t cfg_d, cfg_q;

    // bits of the words that carry no timing for this block
    logic unused_bits;
    assign unused_bits = ^{htim_i[HPPL_LSB-1:0], ctim_i[INV_VS_BIT-1:0],
                           ctim_i[31:INV_OE_BIT+1]};

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = decode_cfg(htim_i, vtim_i, ctim_i, dual_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/lcd_tim_axis.sv
module lcd_tim_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_bp,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_fp,
    output logic [W-1:0] idx_o,
    output logic         wrap_o,
    output logic         in_sync_o,
    output logic         in_act_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] pos_d, pos_q;
    logic [W-1:0] b_act, b_fp, total;

    // segment boundaries in scan order: sync, back porch, active, front porch
    assign b_act = len_sync + len_bp;
    assign b_fp  = b_act + len_act;
    assign total = b_fp + len_fp;

    assign wrap_o    = (pos_q == total - ONE);
    assign in_sync_o = (pos_q < len_sync);
    assign in_act_o  = (pos_q >= b_act) && (pos_q < b_fp);
    assign idx_o     = pos_q - b_act;

    always_comb begin
        pos_d = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (adv) begin
            pos_d = wrap_o ? '0 : pos_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // R4: position only moves on a pixel tick
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear) |=> $stable(pos_q));

    // R1 / R2: position never passes the end of the period
    a_r1_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && total != '0) |-> (pos_q < total));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tim_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           dual_panel,
    input  logic [31:0]    htim,
    input  logic [31:0]    vtim,
    input  logic [31:0]    ctim,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pix_act,
    output logic           lo_act,
    output logic           frame_start,
    output logic           panel_clk,
    output logic [H_W-1:0] x_pos,
    output logic [V_W-1:0] y_pos,
    output logic [V_W-1:0] y_lo_pos
);

    ctl_t  ctl_d, ctl_q;
    tcfg_t cfg;

    logic           tick, v_adv, end_frame, load, clear, act;
    logic [H_W-1:0] h_idx;
    logic [V_W-1:0] v_idx;
    logic           h_wrap, h_sync, h_act;
    logic           v_wrap, v_sync, v_act;

    // control state: registered enable and pixel phase
    always_comb begin
        ctl_d.en    = enable;
        ctl_d.phase = ctl_q.en ? ~ctl_q.phase : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clear     = ~ctl_q.en;
    assign tick      = ctl_q.en & ctl_q.phase;
    assign v_adv     = tick & h_wrap;
    assign end_frame = v_adv & v_wrap;
    assign load      = clear | end_frame;

    lcd_tim_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .htim_i (htim),
        .vtim_i (vtim),
        .ctim_i (ctim),
        .dual_i (dual_panel),
        .cfg_o  (cfg)
    );

    lcd_tim_axis #(.W(H_W)) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .adv       (tick),
        .len_sync  (cfg.hsw),
        .len_bp    (cfg.hbp),
        .len_act   (cfg.hact),
        .len_fp    (cfg.hfp),
        .idx_o     (h_idx),
        .wrap_o    (h_wrap),
        .in_sync_o (h_sync),
        .in_act_o  (h_act)
    );

    lcd_tim_axis #(.W(V_W)) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .adv       (v_adv),
        .len_sync  (cfg.vsw),
        .len_bp    (cfg.vbp),
        .len_act   (cfg.vact),
        .len_fp    (cfg.vfp),
        .idx_o     (v_idx),
        .wrap_o    (v_wrap),
        .in_sync_o (v_sync),
        .in_act_o  (v_act)
    );

    assign act         = ctl_q.en & h_act & v_act;
    assign pix_act     = act;
    assign lo_act      = act & cfg.dual;
    assign de          = act ^ cfg.inv_oe;
    assign hsync       = (ctl_q.en & h_sync) ^ cfg.inv_hs;
    assign vsync       = (ctl_q.en & v_sync) ^ cfg.inv_vs;
    assign panel_clk   = (ctl_q.en & ctl_q.phase) ^ cfg.inv_pc;
    assign x_pos       = act ? h_idx : '0;
    assign y_pos       = act ? v_idx : '0;
    assign y_lo_pos    = (act & cfg.dual) ? (v_idx + cfg.vact) : '0;
    assign frame_start = act & ~ctl_q.phase & (h_idx == '0) & (v_idx == '0);

    // R3: the active strobe never overlaps either sync segment
    a_r3_act_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        pix_act |-> (!h_sync && !v_sync));

    // R6: frame start lasts one clock cycle
    a_r6_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8: disabled block shows no activity
    a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> (!pix_act && !frame_start && x_pos == '0 && y_pos == '0));

    // R9: lower strobe only in dual mode, together with the main strobe
    a_r9_lower_only_dual: assert property (@(posedge clk) disable iff (!rst_n)
        lo_act |-> (pix_act && cfg.dual));

    // R7: timing held steady within a running frame
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.en && !end_frame) |=> $stable(cfg));

endmodule

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
    import lcd_tim_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n, enable, dual_panel;
    logic [31:0]    htim, vtim, ctim;
    logic           hsync, vsync, de, pix_act, lo_act, frame_start, panel_clk;
    logic [H_W-1:0] x_pos;
    logic [V_W-1:0] y_pos, y_lo_pos;

    int total_chk = 0;
    int bad_chk   = 0;
    bit done      = 1'b0;

    lcd_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dual_panel(dual_panel),
        .htim(htim), .vtim(vtim), .ctim(ctim),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_act(pix_act),
        .lo_act(lo_act), .frame_start(frame_start), .panel_clk(panel_clk),
        .x_pos(x_pos), .y_pos(y_pos), .y_lo_pos(y_lo_pos)
    );

    // {dual, ctim, vtim, htim}
    localparam logic [96:0] VEC [4] = '{
        {1'b0, 32'h0000_0000, 32'h0101_0403, 32'h0505_0500},
        {1'b0, 32'h0000_5800, 32'h0000_0001, 32'h0609_0704},
        {1'b1, 32'h0000_2000, 32'h0203_0805, 32'h0505_0500},
        {1'b1, 32'h0000_0800, 32'h0002_0000, 32'h0505_0508}
    };

    function automatic int f_hsw(input logic [31:0] h);  return int'(h[15:8]) + 1; endfunction
    function automatic int f_hfp(input logic [31:0] h);  return int'(h[23:16]) + 1; endfunction
    function automatic int f_hbp(input logic [31:0] h);  return int'(h[31:24]) + 1; endfunction
    function automatic int f_hact(input logic [31:0] h); return (int'(h[7:2]) + 1) * 16; endfunction
    function automatic int f_htot(input logic [31:0] h);
        return f_hsw(h) + f_hbp(h) + f_hact(h) + f_hfp(h);
    endfunction
    function automatic int f_lines(input logic [31:0] v); return int'(v[9:0]) + 1; endfunction
    function automatic int f_vsw(input logic [31:0] v);   return int'(v[15:10]) + 1; endfunction
    function automatic int f_vfp(input logic [31:0] v);   return int'(v[23:16]); endfunction
    function automatic int f_vbp(input logic [31:0] v);   return int'(v[31:24]); endfunction
    function automatic int f_vtot(input logic [31:0] v);
        return f_vsw(v) + f_vbp(v) + f_lines(v) + f_vfp(v);
    endfunction

    task automatic check(input string req, input string what, input int actv, input int expv);
        total_chk++;
        if (actv != expv) begin
            bad_chk++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actv, expv);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad_chk++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic run_vector(input logic [96:0] vv);
        logic [31:0] h, v, c;
        logic        d;
        int n, act, deact, hs, vs, lo, pc, fs, mx, my;
        h = vv[31:0]; v = vv[63:32]; c = vv[95:64]; d = vv[96];
        enable = 1'b0;
        htim = h; vtim = v; ctim = c; dual_panel = d;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_fs();
        check("R10", "first x", int'(x_pos), 0);
        check("R10", "first y", int'(y_pos), 0);
        check("R9", "first lower row", int'(y_lo_pos), d ? f_lines(v) : 0);
        check("R4", "panel clk first half", int'(panel_clk), int'(c[INV_PC_BIT]));
        n = 0; act = 0; deact = 0; hs = 0; vs = 0; lo = 0; pc = 0; fs = 0; mx = 0; my = 0;
        do begin
            if (n == 1) begin
                check("R4", "panel clk second half", int'(panel_clk), int'(!c[INV_PC_BIT]));
                check("R4", "x held over pixel", int'(x_pos), 0);
            end
            if (n == 2) check("R4", "x after one pixel", int'(x_pos), 1);
            act   += int'(pix_act);
            deact += int'(de != c[INV_OE_BIT]);
            hs    += int'(hsync != c[INV_HS_BIT]);
            vs    += int'(vsync != c[INV_VS_BIT]);
            lo    += int'(lo_act);
            pc    += int'(panel_clk != c[INV_PC_BIT]);
            fs    += int'(frame_start);
            if (pix_act && int'(x_pos) > mx) mx = int'(x_pos);
            if (pix_act && int'(y_pos) > my) my = int'(y_pos);
            n++;
            @(negedge clk);
        end while (!frame_start);
        check("R1", "frame period clks", n, 2 * f_htot(h) * f_vtot(v));
        check("R2", "vsync active clks", vs, 2 * f_vsw(v) * f_htot(h));
        check("R1", "hsync active clks", hs, 2 * f_hsw(h) * f_vtot(v));
        check("R3", "active clks", act, 2 * f_hact(h) * f_lines(v));
        check("R5", "output enable active clks", deact, act);
        check("R4", "panel clk high clks", pc, n / 2);
        check("R6", "frame starts per frame", fs, 1);
        check("R9", "lower strobe clks", lo, d ? act : 0);
        check("R10", "max column", mx, f_hact(h) - 1);
        check("R2", "max row", my, f_lines(v) - 1);
    endtask

    initial begin
        int n, m, offs;
        logic prev;
        rst_n = 1'b0; enable = 1'b0; dual_panel = 1'b0;
        htim = VEC[0][31:0]; vtim = VEC[0][63:32]; ctim = 32'h0000_5800;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset/idle state with inverted syncs and output enable
        check("R8", "idle hsync", int'(hsync), 1);
        check("R8", "idle vsync", int'(vsync), 1);
        check("R8", "idle de", int'(de), 1);
        check("R8", "idle strobe", int'(pix_act), 0);
        check("R8", "idle frame start", int'(frame_start), 0);
        check("R8", "idle x", int'(x_pos), 0);
        check("R8", "idle panel clk", int'(panel_clk), 0);

        for (int i = 0; i < 4; i++) begin
            run_vector(VEC[i]);
        end

        // R7 / R3: write mid-frame, current frame keeps old timing
        run_vector(VEC[0]);
        wait_fs();
        htim = VEC[1][31:0];
        offs = 2 * ((f_vsw(VEC[0][63:32]) + f_vbp(VEC[0][63:32])) * f_htot(VEC[0][31:0])
                    + f_hsw(VEC[0][31:0]) + f_hbp(VEC[0][31:0]));
        n = 0;
        do begin @(negedge clk); n++; end while (!vsync);
        check("R3/R7", "clks from frame start to next vsync",
              n, 2 * f_htot(VEC[0][31:0]) * f_vtot(VEC[0][63:32]) - offs);
        m = 0; prev = 1'b1;
        do begin prev = vsync; @(negedge clk); m++; end while (!(vsync && !prev));
        check("R7", "period with new timing", m, 2 * f_htot(VEC[1][31:0]) * f_vtot(VEC[0][63:32]));

        // R8: drop enable during active video
        do @(negedge clk); while (!pix_act);
        enable = 1'b0;
        @(negedge clk);
        check("R8", "strobe after disable", int'(pix_act), 0);
        check("R8", "de after disable", int'(de), 0);
        check("R8", "hsync after disable", int'(hsync), 0);
        check("R8", "vsync after disable", int'(vsync), 0);
        check("R8", "panel clk after disable", int'(panel_clk), 0);
        check("R8", "x after disable", int'(x_pos), 0);
        @(negedge clk);
        check("R8", "strobe stays low", int'(pix_act), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule